// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Pending Controller

This block holds the receive-pending and transmit-pending flags of a two-channel serial controller. It gathers them into one pending-status byte and merges every channel's receive, transmit and break requests into a single interrupt line. The register-access logic next to it raises short set and clear pulses for each flag. It also drives the enable fields decoded from the channel control registers and the break-detected status bit of each channel. The host reads the pending-status byte through channel A.

Each channel raises a request only while its master interrupt enable is set. Receive requests are qualified by a 2-bit receive-interrupt mode, not by a single enable bit. The requests of both channels are ORed and registered once, so the interrupt line follows the flags and enables one clock later.

Top module: `serint_irq_ctrl`

## Requirements
- R1: A channel contributes no interrupt while its master enable `mie_i[c]` (control register 1, bit 0) is low, whatever its pending flags and break state.
- R2: With the master enable set, a channel requests an interrupt when its transmit enable `txe_i[c]` (control register 1, bit 1) is high and its transmit-pending flag is set.
- R3: With the master enable set, a channel requests an interrupt when its receive-pending flag is set and its 2-bit receive mode `rx_mode_i[2c+1:2c]` (control register 1, bits 4:3) is 2'b01 or 2'b10. Modes 2'b00 and 2'b11 never request.
- R4: With the master enable set, a channel requests an interrupt when its break enable `brk_en_i[c]` (control register 15, bit 7) and its break status `brk_stat_i[c]` (status register 0, bit 7) are both high. The break status of one channel has no effect on the other channel.
- R5: The pending-status byte shows channel A receive in bit 5, channel A transmit in bit 4, channel B receive in bit 2 and channel B transmit in bit 1. Channel A is index 0 and channel B is index 1. All other bits read 0.
- R6: A set or clear pulse sampled at a clock edge updates its flag, and its status bit, right after that edge. With no pulse, the flag holds its value.
- R7: When a set pulse and a clear pulse for the same flag arrive in the same cycle, the flag ends up set.
- R8: `irq_o` is the OR of both channels' requests. It is registered, so it reflects the flags and enables present at the previous clock edge.
- R9: An active-low reset clears all pending flags and drives `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_set_i | input | NUM_CH | Per-channel pulse that sets receive-pending |
| rx_clr_i | input | NUM_CH | Per-channel pulse that clears receive-pending |
| tx_set_i | input | NUM_CH | Per-channel pulse that sets transmit-pending |
| tx_clr_i | input | NUM_CH | Per-channel pulse that clears transmit-pending |
| mie_i | input | NUM_CH | Master interrupt enable per channel |
| txe_i | input | NUM_CH | Transmit interrupt enable per channel |
| rx_mode_i | input | 2*NUM_CH | Receive interrupt mode, 2 bits per channel |
| brk_en_i | input | NUM_CH | Break interrupt enable per channel |
| brk_stat_i | input | NUM_CH | Break detected status per channel |
| pend_status_o | output | 8 | Pending-status byte, read through channel A |
| irq_o | output | 1 | Merged, registered interrupt request level |

## Verification
A pulse sampled at edge k changes the flag and the pending-status byte right after edge k. The interrupt line reacts one edge later, at edge k+1. A change of an enable or break input therefore shows on `irq_o` after the next edge. The bench drives at the falling edge, reads the status byte at the falling edge after the first rising edge, and reads `irq_o` one full cycle later. A directed test also checks that `irq_o` is still low at the intermediate sample.

// File: rtl/serint_pkg.sv
package serint_pkg;

   localparam int STATUS_W = 8;

   // Receive-interrupt qualifier values
   typedef enum logic [1:0] {
      RXM_NONE  = 2'b00,
      RXM_FIRST = 2'b01,
      RXM_EVERY = 2'b10,
      RXM_SPEC  = 2'b11
   } rx_mode_e;

   typedef struct packed {
      logic     mie;
      logic     txe;
      rx_mode_e rxm;
      logic     brk_en;
      logic     brk;
   } chan_cfg_t;

   // Status-byte positions; channel 0 is A, channel 1 is B
   function automatic int rx_bit(input int ch);
      return (ch == 0) ? 5 : 2;
   endfunction

   function automatic int tx_bit(input int ch);
      return (ch == 0) ? 4 : 1;
   endfunction

endpackage

// File: rtl/serint_pend_flag.sv
module serint_pend_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set_i)
         flag_q <= 1'b1;
      else if (clr_i)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R7: set has priority over a simultaneous clear
   a_r7_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

   // R6: a lone clear empties the flag on the next cycle
   a_r6_clear_takes : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);

   // R6: without pulses the flag keeps its value
   a_r6_flag_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(flag_o));

endmodule

// File: rtl/serint_chan_req.sv
module serint_chan_req
   import serint_pkg::*;
(
   input  chan_cfg_t cfg_i,
   input  logic      rx_pend_i,
   input  logic      tx_pend_i,
   output logic      req_o
);

   logic rx_qual;
   logic rx_req;
   logic tx_req;
   logic brk_req;

   always_comb begin
      case (cfg_i.rxm)
         RXM_FIRST, RXM_EVERY: rx_qual = 1'b1;
         default:              rx_qual = 1'b0;
      endcase
   end

   assign rx_req  = rx_qual && rx_pend_i;
   assign tx_req  = cfg_i.txe && tx_pend_i;
   assign brk_req = cfg_i.brk_en && cfg_i.brk;
   assign req_o   = cfg_i.mie && (rx_req || tx_req || brk_req);

endmodule

// File: rtl/serint_status_map.sv
module serint_status_map
   import serint_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic [NUM_CH-1:0]   rx_pend_i,
   input  logic [NUM_CH-1:0]   tx_pend_i,
   output logic [STATUS_W-1:0] status_o
);

   always_comb begin
      status_o = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         status_o[rx_bit(c)] = rx_pend_i[c];
         status_o[tx_bit(c)] = tx_pend_i[c];
      end
   end

endmodule

// File: rtl/serint_irq_ctrl.sv
module serint_irq_ctrl
   import serint_pkg::*;
#(
   parameter int NUM_CH         = 2,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CH-1:0]     rx_set_i,
   input  logic [NUM_CH-1:0]     rx_clr_i,
   input  logic [NUM_CH-1:0]     tx_set_i,
   input  logic [NUM_CH-1:0]     tx_clr_i,
   input  logic [NUM_CH-1:0]     mie_i,
   input  logic [NUM_CH-1:0]     txe_i,
   input  logic [2*NUM_CH-1:0]   rx_mode_i,
   input  logic [NUM_CH-1:0]     brk_en_i,
   input  logic [NUM_CH-1:0]     brk_stat_i,
   output logic [STATUS_W-1:0]   pend_status_o,
   output logic                  irq_o
);

   localparam int MODE_W = 2;

   if (NUM_CH != 2) begin : g_bad_ch
      $error("serint_irq_ctrl: the status byte layout holds exactly two channels");
   end

   logic [NUM_CH-1:0] rx_pend;
   logic [NUM_CH-1:0] tx_pend;
   logic [NUM_CH-1:0] chan_req;
   logic              any_req;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      chan_cfg_t cfg;

      assign cfg.mie    = mie_i[c];
      assign cfg.txe    = txe_i[c];
      assign cfg.rxm    = rx_mode_e'(rx_mode_i[c*MODE_W +: MODE_W]);
      assign cfg.brk_en = brk_en_i[c];
      assign cfg.brk    = brk_stat_i[c];

      serint_pend_flag u_rx_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (rx_set_i[c]),
         .clr_i  (rx_clr_i[c]),
         .flag_o (rx_pend[c])
      );

      serint_pend_flag u_tx_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (tx_set_i[c]),
         .clr_i  (tx_clr_i[c]),
         .flag_o (tx_pend[c])
      );

      serint_chan_req u_req (
         .cfg_i     (cfg),
         .rx_pend_i (rx_pend[c]),
         .tx_pend_i (tx_pend[c]),
         .req_o     (chan_req[c])
      );
   end

   serint_status_map #(.NUM_CH(NUM_CH)) u_status (
      .rx_pend_i (rx_pend),
      .tx_pend_i (tx_pend),
      .status_o  (pend_status_o)
   );

   assign any_req = |chan_req;

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            irq_q <= 1'b0;
         else
            irq_q <= any_req;
      end

      assign irq_o = irq_q;

      // R1: no master enable anywhere -> line low one cycle later
      a_r1_master_gate : assert property (@(posedge clk) disable iff (!rst_n)
         (mie_i == '0) |=> !irq_o);

      // R8: any channel request shows on the line one cycle later
      a_r8_irq_rises : assert property (@(posedge clk) disable iff (!rst_n)
         (|chan_req) |=> irq_o);

      // R8: no request -> line drops one cycle later
      a_r8_irq_falls : assert property (@(posedge clk) disable iff (!rst_n)
         !(|chan_req) |=> !irq_o);
   end else begin : g_irq_comb
      assign irq_o = any_req;
   end

   // R6: without any pulse the status byte is unchanged
   a_r6_status_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_set_i == '0 && rx_clr_i == '0 && tx_set_i == '0 && tx_clr_i == '0)
      |=> $stable(pend_status_o));

endmodule

// File: tb/serint_irq_ctrl_bench.sv
module serint_irq_ctrl_bench;

   localparam int NCH = 2;

   typedef struct packed {
      logic [1:0] rxs;
      logic [1:0] rxc;
      logic [1:0] txs;
      logic [1:0] txc;
      logic [1:0] mie;
      logic [1:0] txe;
      logic [3:0] rxm;
      logic [1:0] bre;
      logic [1:0] brk;
      logic [7:0] st;
      logic       irq;
   } vec_t;

   // Fields: rxs rxc txs txc mie txe rxm(B,A) bre brk | status irq ; bit0 = channel A
   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      {2'b00,2'b00,2'b00,2'b00, 2'b00,2'b00,4'b0000,2'b00,2'b00, 8'h00,1'b0}, // idle
      {2'b01,2'b00,2'b00,2'b00, 2'b00,2'b00,4'b0001,2'b00,2'b00, 8'h20,1'b0}, // R1 A rx, master off
      {2'b00,2'b00,2'b00,2'b00, 2'b01,2'b00,4'b0000,2'b00,2'b00, 8'h20,1'b0}, // R3 mode 00
      {2'b00,2'b00,2'b00,2'b00, 2'b01,2'b00,4'b0001,2'b00,2'b00, 8'h20,1'b1}, // R3 mode 01
      {2'b00,2'b00,2'b00,2'b00, 2'b01,2'b00,4'b0010,2'b00,2'b00, 8'h20,1'b1}, // R3 mode 10
      {2'b00,2'b00,2'b00,2'b00, 2'b01,2'b00,4'b0011,2'b00,2'b00, 8'h20,1'b0}, // R3 mode 11
      {2'b00,2'b00,2'b00,2'b00, 2'b00,2'b00,4'b0010,2'b00,2'b00, 8'h20,1'b0}, // R1 master off
      {2'b00,2'b01,2'b00,2'b00, 2'b01,2'b00,4'b0010,2'b00,2'b00, 8'h00,1'b0}, // R6 clear A rx
      {2'b00,2'b00,2'b10,2'b00, 2'b10,2'b00,4'b0000,2'b00,2'b00, 8'h02,1'b0}, // R2 B tx, txe off
      {2'b00,2'b00,2'b00,2'b00, 2'b10,2'b10,4'b0000,2'b00,2'b00, 8'h02,1'b1}, // R2 txe on
      {2'b00,2'b00,2'b00,2'b10, 2'b10,2'b10,4'b0000,2'b00,2'b00, 8'h00,1'b0}, // R6 clear B tx
      {2'b00,2'b00,2'b10,2'b10, 2'b10,2'b10,4'b0000,2'b00,2'b00, 8'h02,1'b1}, // R7 set+clear
      {2'b10,2'b00,2'b00,2'b00, 2'b10,2'b10,4'b0100,2'b00,2'b00, 8'h06,1'b1}, // R5 B rx bit 2
      {2'b01,2'b00,2'b01,2'b00, 2'b00,2'b00,4'b0000,2'b00,2'b00, 8'h36,1'b0}, // R5 all four
      {2'b00,2'b11,2'b00,2'b11, 2'b00,2'b00,4'b0000,2'b00,2'b00, 8'h00,1'b0}, // R6 clear all
      {2'b00,2'b00,2'b00,2'b00, 2'b01,2'b00,4'b0000,2'b01,2'b01, 8'h00,1'b1}, // R4 A break
      {2'b00,2'b00,2'b00,2'b00, 2'b00,2'b00,4'b0000,2'b01,2'b01, 8'h00,1'b0}, // R1 break, master off
      {2'b00,2'b00,2'b00,2'b00, 2'b01,2'b00,4'b0000,2'b00,2'b01, 8'h00,1'b0}, // R4 break not enabled
      {2'b00,2'b00,2'b00,2'b00, 2'b10,2'b00,4'b0000,2'b10,2'b10, 8'h00,1'b1}, // R4 B break
      {2'b00,2'b00,2'b00,2'b00, 2'b10,2'b00,4'b0000,2'b10,2'b01, 8'h00,1'b0}, // R4 no cross-channel
      {2'b01,2'b00,2'b00,2'b00, 2'b11,2'b00,4'b0001,2'b10,2'b10, 8'h20,1'b1}  // R8 both channels
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NCH-1:0]   rx_set = '0, rx_clr = '0, tx_set = '0, tx_clr = '0;
   logic [NCH-1:0]   mie = '0, txe = '0, bre = '0, brk = '0;
   logic [2*NCH-1:0] rxm = '0;
   logic [7:0]       status;
   logic             irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   serint_irq_ctrl u_serint_irq_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_set_i      (rx_set),
      .rx_clr_i      (rx_clr),
      .tx_set_i      (tx_set),
      .tx_clr_i      (tx_clr),
      .mie_i         (mie),
      .txe_i         (txe),
      .rx_mode_i     (rxm),
      .brk_en_i      (bre),
      .brk_stat_i    (brk),
      .pend_status_o (status),
      .irq_o         (irq)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   task automatic clear_pulses();
      rx_set = '0; rx_clr = '0; tx_set = '0; tx_clr = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      check("R9", "status in reset", 32'(status), 32'h00);
      check("R9", "irq in reset", 32'(irq), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: status due after one edge, irq after the next
      for (int i = 0; i < NV; i++) begin
         rx_set = VECS[i].rxs; rx_clr = VECS[i].rxc;
         tx_set = VECS[i].txs; tx_clr = VECS[i].txc;
         mie = VECS[i].mie; txe = VECS[i].txe; rxm = VECS[i].rxm;
         bre = VECS[i].bre; brk = VECS[i].brk;
         @(posedge clk);
         @(negedge clk);
         clear_pulses();
         check("R5/R6/R7", $sformatf("vector %0d status", i), 32'(status), 32'(VECS[i].st));
         @(posedge clk);
         @(negedge clk);
         check("R1-4/R8", $sformatf("vector %0d irq", i), 32'(irq), 32'(VECS[i].irq));
      end

      // R8: latency -- irq still low one sample after the flag appears
      mie = 2'b00; txe = '0; rxm = '0; bre = '0; brk = '0;
      rx_clr = 2'b11; tx_clr = 2'b11;
      @(posedge clk); @(negedge clk);
      clear_pulses();
      mie = 2'b10; txe = 2'b10;
      @(posedge clk); @(negedge clk);
      check("R8", "idle before latency", 32'(irq), 32'h0);
      tx_set = 2'b10;
      @(posedge clk); @(negedge clk);
      clear_pulses();
      check("R6", "B tx status immediate", 32'(status), 32'h02);
      check("R8", "irq not yet raised", 32'(irq), 32'h0);
      @(posedge clk); @(negedge clk);
      check("R8", "irq raised next cycle", 32'(irq), 32'h1);

      // R9: reset during activity clears everything
      rx_set = 2'b01;
      @(posedge clk); @(negedge clk);
      clear_pulses();
      check("R5", "A rx plus B tx", 32'(status), 32'h22);
      rst_n = 1'b0;
      #1;
      check("R9", "status after mid reset", 32'(status), 32'h00);
      check("R9", "irq after mid reset", 32'(irq), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R9", "irq stays low after reset", 32'(irq), 32'h0);

      finish_run();
   end

endmodule